// File: doc/BRIEF.md
# Bus Response Timeout Guard

This block sits beside a single-master, processor-internal bus and makes sure that every access ends. An access opens with a read or write strobe that is high for exactly one clock cycle. From the cycle after the strobe, the guard counts cycles until the addressed device answers with an acknowledge (success) or an error (failure). It passes that answer to the requester in the same cycle. If the device stays silent for the whole response window, the guard ends the access itself. It does this with a one-cycle error pulse and a timeout flag, which the CPU turns into a bus-fault exception.

The request sidebands pass straight through the guard without change: byte enables, source (0 = instruction fetch, 1 = load/store), privilege and reservation-operation. A strobe that arrives while an access is still open is reported as a protocol violation and does not disturb the running window. The reset is asynchronous and active-low, and the guard releases it in step with the clock.

Top module: `bus_resp_guard`

## Requirements
- R1: While reset is active, and in the cycles after release until the first strobe, `cpu_ack_o`, `cpu_err_o`, `tmo_o` and `proto_viol_o` are all 0.
- R2: A read or write strobe seen while no access is open starts an access. Cycle 1 of its window is the clock cycle right after the strobe.
- R3: A device ACK during window cycle k (1 <= k <= `RESP_WINDOW`) shows on `cpu_ack_o` in that same cycle with `cpu_err_o` low, and the access closes at the end of that cycle.
- R4: A device ERR during window cycle k (1 <= k <= `RESP_WINDOW`) shows on `cpu_err_o` in that same cycle with `tmo_o` low, and the access closes.
- R5: A response in the last window cycle (k = `RESP_WINDOW`, 15 by default) is valid and produces no timeout.
- R6: If no ACK or ERR arrives in window cycles 1..`RESP_WINDOW`, then `cpu_err_o` and `tmo_o` are both high for exactly one cycle, in cycle `RESP_WINDOW`+1.
- R7: A device ACK or ERR while no access is open has no effect. This covers the strobe cycle, the timeout-pulse cycle and any cycle after an access closes. `cpu_ack_o` stays 0, and `cpu_err_o` is 0 unless a timeout pulse is being driven.
- R8: A strobe while an access is open drives `proto_viol_o` high in that cycle and does not restart the window. The timeout still falls `RESP_WINDOW`+1 cycles after the original strobe.
- R9: `fwd_ben_o` (4 bits), `fwd_src_o`, `fwd_priv_o` and `fwd_rsv_o` equal `req_ben_i`, `req_src_i`, `req_priv_i` and `req_rsv_i` in the same cycle, for every value.
- R10: A strobe in the cycle after an access closed on a response opens a fresh window of full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd_i | input | 1 | Read strobe, one cycle |
| req_wr_i | input | 1 | Write strobe, one cycle |
| req_ben_i | input | 4 | Byte enables of the request |
| req_src_i | input | 1 | Source: 0 instruction fetch, 1 load/store |
| req_priv_i | input | 1 | Privileged access |
| req_rsv_i | input | 1 | Reservation-set operation |
| dev_ack_i | input | 1 | Device acknowledge |
| dev_err_i | input | 1 | Device error |
| fwd_ben_o | output | 4 | Byte enables passed on |
| fwd_src_o | output | 1 | Source bit passed on |
| fwd_priv_o | output | 1 | Privilege bit passed on |
| fwd_rsv_o | output | 1 | Reservation bit passed on |
| cpu_ack_o | output | 1 | Merged acknowledge to the requester |
| cpu_err_o | output | 1 | Merged error (device error or timeout) |
| tmo_o | output | 1 | Timeout pulse |
| proto_viol_o | output | 1 | Strobe seen while an access is open |

## Verification
The assertions assume three things about the inputs. A device never raises ACK and ERR in the same cycle. Read and write strobes are never high together. Each strobe lasts a single cycle. The stimulus keeps to all three: it drives one response line at a time and one strobe at a time, and it clears each strobe in the cycle after it is raised. The only overlap it creates on purpose is a strobe inside an open window, which is the protocol-violation case the guard has to report.

// File: rtl/bus_resp_guard_pkg.sv
package bus_resp_guard_pkg;
  typedef enum logic {
    GUARD_IDLE = 1'b0,
    GUARD_WAIT = 1'b1
  } guard_state_e;
endpackage

// File: rtl/brg_reset_sync.sv
module brg_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/brg_window_timer.sv
module brg_window_timer
  import bus_resp_guard_pkg::*;
#(
  parameter int LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  guard_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;
  logic             cnt_en;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    exp_d   = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      GUARD_IDLE: begin
        if (start_i) begin
          state_d = GUARD_WAIT;
          cnt_d   = ONE;
          cnt_en  = 1'b1;
        end
      end
      GUARD_WAIT: begin
        cnt_en = 1'b1;
        if (done_i) begin
          state_d = GUARD_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = GUARD_IDLE;
          cnt_d   = '0;
          exp_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: begin
        state_d = GUARD_IDLE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GUARD_IDLE;
      exp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      exp_q   <= exp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o    = (state_q == GUARD_WAIT);
  assign expired_o = exp_q;

  assert_cnt_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GUARD_IDLE && start_i) |=> (busy_o && cnt_q == ONE));

  assert_expiry_after_silence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |-> ($past(busy_o) && !$past(done_i)));

  assert_expiry_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |=> !expired_o);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/brg_resp_merge.sv
module brg_resp_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic expired_i,
  input  logic strobe_i,
  input  logic dev_ack_i,
  input  logic dev_err_i,
  output logic cpu_ack_o,
  output logic cpu_err_o,
  output logic tmo_o,
  output logic viol_o
);
  assign cpu_ack_o = busy_i & dev_ack_i;
  assign cpu_err_o = (busy_i & dev_err_i) | expired_i;
  assign tmo_o     = expired_i;
  assign viol_o    = busy_i & strobe_i;

  assert_ack_needs_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack_o |-> busy_i);

  assert_tmo_is_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> (cpu_err_o && !cpu_ack_o));

  assert_tmo_not_while_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> !busy_i);

  assert_ack_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack_o && !strobe_i) |=> !busy_i);
endmodule

// File: rtl/bus_resp_guard.sv
module bus_resp_guard #(
  parameter int RESP_WINDOW = 15,
  parameter int BEN_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_rd_i,
  input  logic             req_wr_i,
  input  logic [BEN_W-1:0] req_ben_i,
  input  logic             req_src_i,
  input  logic             req_priv_i,
  input  logic             req_rsv_i,
  input  logic             dev_ack_i,
  input  logic             dev_err_i,
  output logic [BEN_W-1:0] fwd_ben_o,
  output logic             fwd_src_o,
  output logic             fwd_priv_o,
  output logic             fwd_rsv_o,
  output logic             cpu_ack_o,
  output logic             cpu_err_o,
  output logic             tmo_o,
  output logic             proto_viol_o
);
  logic rst_n_s;
  logic strobe;
  logic resp;
  logic busy;
  logic expired;

  assign strobe = req_rd_i | req_wr_i;
  assign resp   = dev_ack_i | dev_err_i;

  // sidebands travel untouched
  assign fwd_ben_o  = req_ben_i;
  assign fwd_src_o  = req_src_i;
  assign fwd_priv_o = req_priv_i;
  assign fwd_rsv_o  = req_rsv_i;

  brg_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  brg_window_timer #(.LIMIT(RESP_WINDOW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (strobe),
    .done_i    (resp),
    .busy_o    (busy),
    .expired_o (expired)
  );

  brg_resp_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .busy_i    (busy),
    .expired_i (expired),
    .strobe_i  (strobe),
    .dev_ack_i (dev_ack_i),
    .dev_err_i (dev_err_i),
    .cpu_ack_o (cpu_ack_o),
    .cpu_err_o (cpu_err_o),
    .tmo_o     (tmo_o),
    .viol_o    (proto_viol_o)
  );

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(req_rd_i && req_wr_i));

  assert_err_reason_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_err_o && !tmo_o) |-> dev_err_i);
endmodule

// File: tb/sim_bus_resp_guard.sv
`timescale 1ns/1ps
module sim_bus_resp_guard;
  localparam int W = 15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd, wr, ack, err, src, priv, rsv;
  logic [3:0] ben;
  logic [3:0] f_ben;
  logic       f_src, f_priv, f_rsv, c_ack, c_err, tmo, viol;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  bus_resp_guard #(.RESP_WINDOW(W), .BEN_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_rd_i(rd), .req_wr_i(wr),
    .req_ben_i(ben), .req_src_i(src), .req_priv_i(priv), .req_rsv_i(rsv),
    .dev_ack_i(ack), .dev_err_i(err),
    .fwd_ben_o(f_ben), .fwd_src_o(f_src), .fwd_priv_o(f_priv), .fwd_rsv_o(f_rsv),
    .cpu_ack_o(c_ack), .cpu_err_o(c_err), .tmo_o(tmo), .proto_viol_o(viol)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // outputs packed: {ack, err, tmo, viol}
  function automatic int outs();
    return {c_ack, c_err, tmo, viol};
  endfunction

  // advance one cycle, drive, let it settle
  task automatic cyc(input logic r, input logic w, input logic a, input logic e);
    @(posedge clk);
    #1;
    rd = r; wr = w; ack = a; err = e;
    #1;
  endtask

  // one access, response of kind (1=ack,2=err) in window cycle k
  task automatic access_resp(input int k, input int kind, input string req);
    cyc(1, 0, 1, 0);
    chk({req, " R7 strobe-cycle ack ignored"}, outs(), 0);
    for (int c = 1; c < k; c++) begin
      cyc(0, 0, 0, 0);
      chk({req, " R2 quiet wait"}, outs(), 0);
    end
    cyc(0, 0, kind == 1, kind == 2);
    chk({req, " R3/R4 response"}, outs(), (kind == 1) ? 8 : 4);
    cyc(0, 0, kind == 1, kind == 2);
    chk({req, " R7 late response ignored"}, outs(), 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic access_timeout(input int viol_at, input string req);
    cyc(0, 1, 0, 0);
    chk({req, " R2 strobe"}, outs(), 0);
    for (int c = 1; c <= W; c++) begin
      cyc(0, c == viol_at, 0, 0);
      chk({req, " R8 wait/violation"}, outs(), (c == viol_at) ? 1 : 0);
    end
    cyc(0, 0, 1, 0);
    chk({req, " R6 timeout pulse, R7 ack ignored"}, outs(), 6);
    cyc(0, 0, 0, 1);
    chk({req, " R6 single pulse, R7 err ignored"}, outs(), 0);
    cyc(0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; rd = 0; wr = 0; ack = 0; err = 0;
    ben = 4'h0; src = 0; priv = 0; rsv = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 outputs in reset", outs(), 0);
    rst_n = 1'b1;
    repeat (4) begin
      cyc(0, 0, 0, 0);
      chk("R1 idle after release", outs(), 0);
    end

    // R9: every sideband combination
    for (int v = 0; v < 128; v++) begin
      @(negedge clk);
      {ben, src, priv, rsv} = 7'(v);
      #1;
      chk("R9 sideband pass-through", int'({f_ben, f_src, f_priv, f_rsv}), v);
    end

    // R3 / R4 / R5: response in every window cycle
    for (int k = 1; k <= W; k++) begin
      access_resp(k, 1, (k == W) ? "R5 ack last" : "R3 ack");
      access_resp(k, 2, (k == W) ? "R5 err last" : "R4 err");
    end

    // R6 and R8: timeout with violation strobe at each window offset
    access_timeout(0, "R6 plain");
    for (int v = 1; v <= W; v++) access_timeout(v, "R8 viol");

    // R10: back-to-back access after a response
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R10 first ack", outs(), 8);
    cyc(1, 0, 0, 0);
    chk("R10 new strobe accepted", outs(), 0);
    for (int c = 1; c <= W; c++) begin
      cyc(0, 0, 0, 0);
      chk("R10 full window", outs(), 0);
    end
    cyc(0, 0, 0, 0);
    chk("R10 timeout at full length", outs(), 6);
    cyc(0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule